// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block owns the four control strobes of an asynchronous EDO-style DRAM (row strobe, column strobe, write enable, output enable). After a synchronous reset it keeps every strobe inactive for a power-up pause. It then runs a counted burst of CAS-before-RAS refresh cycles and only then reports itself ready. From that point it issues one CAS-before-RAS refresh at a fixed interval. The interval is the refresh period divided by the row count, and a parameter selects 4096 or 2048 rows.

A host that wants the strobes raises a request. Once the grant comes back, the host's own strobe values pass to the DRAM pins through one register stage, and they keep doing so until the host drops its request. A refresh that comes due while the host holds the bus is kept pending and runs first after the host lets go. If the time since the last completed refresh grows beyond a limit, the whole wake-up burst runs again before the host is served. Every timing value is given in nanoseconds and turned into whole clock cycles by rounding up against a clock-period parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, all four DRAM strobes are high (inactive), `ready` is 0 and `host_gnt` is 0.
- R2: After reset is released, all four strobes stay high for at least PAUSE_CYC = ceil(PAUSE_NS·1000 / CLK_PERIOD_PS) cycles. The first strobe activity follows within 10 further cycles.
- R3: After the pause, exactly WAKE_COUNT (default 8) refresh cycles run while `ready` is 0, and then `ready` goes to 1.
- R4: In every refresh cycle the column strobe is low for at least CSR_CYC cycles before the row strobe falls. The row strobe stays low for exactly RAS_CYC cycles, and write enable is high throughout.
- R5: With no host traffic, consecutive refresh row-strobe falls are exactly INT_CYC cycles apart. INT_CYC = ceil(REFRESH_PERIOD_NS·1000 / (ROWS·CLK_PERIOD_PS)), where ROWS is 4096 when ROWS_4K = 1 and 2048 when ROWS_4K = 0.
- R6: `host_gnt` is 1 only while `ready` is 1. During the grant, each DRAM strobe equals the matching host strobe input from one cycle earlier. `host_gnt` falls in the cycle after `host_req` is sampled low.
- R7: A refresh that comes due during a host grant runs after the grant ends. A pending refresh is served before a new host request: exactly one refresh cycle comes between the two grants.
- R8: Between refresh cycles the row strobe is high for at least PRE_CYC = max(TRP, TCP) cycles. The column strobe is high for at least TCP_CYC cycles before each refresh pulls it low.
- R9: If more than LAPSE_CYC cycles pass without a completed refresh, `ready` falls and the WAKE_COUNT-cycle burst runs again before any further grant. If that limit is not reached, `ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host asks for the DRAM strobes; held for the whole access |
| host_ras_n | input | 1 | Host row strobe, passed through while granted |
| host_cas_n | input | 1 | Host column strobe, passed through while granted |
| host_we_n | input | 1 | Host write enable, passed through while granted |
| host_oe_n | input | 1 | Host output enable, passed through while granted |
| host_gnt | output | 1 | Host owns the strobes |
| ready | output | 1 | Wake-up burst done; low during pause and any repeat burst |
| dram_ras_n | output | 1 | DRAM row strobe (registered) |
| dram_cas_n | output | 1 | DRAM column strobe (registered) |
| dram_we_n | output | 1 | DRAM write enable (registered) |
| dram_oe_n | output | 1 | DRAM output enable (registered) |

## Verification
Several rules are checked on every cycle by the in-RTL properties: the column strobe is always low when the row strobe falls, a grant never appears without `ready`, strobes stay idle through the pause, a new refresh never starts while the previous one is still in precharge, and a pending refresh blocks a waiting host request. Other behaviour needs the bench's scenarios. These include the exact length of the wake-up burst, the refresh interval for both row counts, and the pass-through latency during a grant. They also include the single deferred refresh that runs between two back-to-back grants, and the repeat burst after a long host hold set against a shorter hold that must leave `ready` alone.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    T_PAUSE, T_WAKE, T_IDLE, T_REF, T_HOST, T_RECOV
  } seq_state_t;

  typedef enum logic [1:0] {
    E_IDLE, E_CSETUP, E_RASLO, E_PRECH
  } eng_state_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input longint ns, input longint clk_ps);
    longint c;
    c = (ns * 64'd1000 + clk_ps - 64'd1) / clk_ps;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  // refresh period spread across the rows, rounded up to cycles
  function automatic int interval_cyc(input longint period_ns, input longint rows,
                                      input longint clk_ps);
    longint den;
    longint c;
    den = rows * clk_ps;
    c = (period_ns * 64'd1000 + den - 64'd1) / den;
    if (c < 2) c = 2;
    return int'(c);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dseq_cbr_engine.sv
module dseq_cbr_engine #(
  parameter int CSR_CYC = 1,
  parameter int RAS_CYC = 3,
  parameter int PRE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  import dseq_pkg::*;

  localparam int MAXC = max2(max2(CSR_CYC, RAS_CYC), PRE_CYC);
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] CSR_LD = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LD = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] PRE_LD = CW'(PRE_CYC - 1);

  eng_state_t st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic done_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    done_n = 1'b0;
    case (st)
      E_IDLE: if (start_i) begin
        st_n  = E_CSETUP;
        cnt_n = CSR_LD;
      end
      E_CSETUP: if (cnt == '0) begin
        st_n  = E_RASLO;
        cnt_n = RAS_LD;
      end else cnt_n = cnt - 1'b1;
      E_RASLO: if (cnt == '0) begin
        st_n  = E_PRECH;
        cnt_n = PRE_LD;
      end else cnt_n = cnt - 1'b1;
      E_PRECH: if (cnt == '0) begin
        st_n   = E_IDLE;
        done_n = 1'b1;
      end else cnt_n = cnt - 1'b1;
      default: st_n = E_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= E_IDLE;
      cnt     <= '0;
      done_o  <= 1'b0;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      done_o  <= done_n;
      ras_n_o <= (st_n != E_RASLO);
      cas_n_o <= !((st_n == E_CSETUP) || (st_n == E_RASLO));
      we_n_o  <= 1'b1;
    end
  end

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n_o) |-> !cas_n_o);

  // R8
  no_restart_in_prech_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (st == E_IDLE));

endmodule

// File: rtl/dseq_refresh_sched.sv
module dseq_refresh_sched #(
  parameter int INT_CYC   = 1563,
  parameter int LAPSE_CYC = 6400000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic ref_done_i,
  output logic pending_o,
  output logic lapse_o
);
  localparam int IW = $clog2(INT_CYC + 1);
  localparam int SW = $clog2(LAPSE_CYC + 1);
  localparam logic [IW-1:0] INT_LD  = IW'(INT_CYC - 1);
  localparam logic [SW-1:0] LAPSE_M = SW'(LAPSE_CYC - 1);

  logic          armed;
  logic [IW-1:0] icnt;
  logic [SW-1:0] scnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      icnt      <= '0;
      scnt      <= '0;
      pending_o <= 1'b0;
      lapse_o   <= 1'b0;
    end else if (arm_i) begin
      armed     <= 1'b1;
      icnt      <= INT_LD;
      scnt      <= '0;
      pending_o <= 1'b0;
      lapse_o   <= 1'b0;
    end else if (armed) begin
      if (ref_done_i) pending_o <= 1'b0;
      if (icnt == '0) begin
        icnt      <= INT_LD;
        pending_o <= 1'b1;
      end else begin
        icnt <= icnt - 1'b1;
      end
      if (ref_done_i) begin
        scnt <= '0;
      end else if (scnt != LAPSE_M) begin
        scnt <= scnt + 1'b1;
      end else begin
        lapse_o <= 1'b1;
      end
    end
  end

  // R9
  lapse_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lapse_o) |-> armed);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CLK_PERIOD_PS     = 20000,
  parameter int PAUSE_NS          = 100000,
  parameter int REFRESH_PERIOD_NS = 128000000,
  parameter bit ROWS_4K           = 1'b1,
  parameter int LAPSE_NS          = 128000000,
  parameter int TCSR_NS           = 10,
  parameter int TRAS_NS           = 50,
  parameter int TRP_NS            = 30,
  parameter int TCP_NS            = 10,
  parameter int WAKE_COUNT        = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic host_req,
  input  logic host_ras_n,
  input  logic host_cas_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic host_gnt,
  output logic ready,
  output logic dram_ras_n,
  output logic dram_cas_n,
  output logic dram_we_n,
  output logic dram_oe_n
);
  import dseq_pkg::*;

  localparam int ROWS      = ROWS_4K ? 4096 : 2048;
  localparam int PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_PERIOD_PS);
  localparam int CSR_CYC   = ns_to_cyc(TCSR_NS, CLK_PERIOD_PS);
  localparam int RAS_CYC   = ns_to_cyc(TRAS_NS, CLK_PERIOD_PS);
  localparam int TCP_CYC   = ns_to_cyc(TCP_NS, CLK_PERIOD_PS);
  localparam int PRE_CYC   = max2(ns_to_cyc(TRP_NS, CLK_PERIOD_PS), TCP_CYC);
  localparam int INT_CYC   = interval_cyc(REFRESH_PERIOD_NS, ROWS, CLK_PERIOD_PS);
  localparam int LAPSE_CYC = ns_to_cyc(LAPSE_NS, CLK_PERIOD_PS);
  localparam int PW        = $clog2(max2(PAUSE_CYC, PRE_CYC) + 1);
  localparam int WW        = $clog2(WAKE_COUNT + 1);
  localparam logic [PW-1:0] PAUSE_LD = PW'(PAUSE_CYC - 1);
  localparam logic [PW-1:0] RECOV_LD = PW'(PRE_CYC - 1);
  localparam logic [WW-1:0] WAKE_LD  = WW'(WAKE_COUNT);

  seq_state_t    state;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] wake_left;
  logic          waiting;
  logic          kick;
  logic          wake_fin;
  logic          eng_done, eng_ras_n, eng_cas_n, eng_we_n;
  logic          ref_pending, lapse;

  dseq_cbr_engine #(
    .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)
  ) eng_i (
    .clk(clk), .rst(rst), .start_i(kick), .done_o(eng_done),
    .ras_n_o(eng_ras_n), .cas_n_o(eng_cas_n), .we_n_o(eng_we_n)
  );

  dseq_refresh_sched #(
    .INT_CYC(INT_CYC), .LAPSE_CYC(LAPSE_CYC)
  ) sched_i (
    .clk(clk), .rst(rst), .arm_i(wake_fin), .ref_done_i(eng_done),
    .pending_o(ref_pending), .lapse_o(lapse)
  );

  assign wake_fin = (state == T_WAKE) && !waiting && (wake_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= T_PAUSE;
      pcnt      <= PAUSE_LD;
      wake_left <= '0;
      waiting   <= 1'b0;
      kick      <= 1'b0;
      ready     <= 1'b0;
      host_gnt  <= 1'b0;
    end else begin
      kick <= 1'b0;
      case (state)
        T_PAUSE: if (pcnt == '0) begin
          state     <= T_WAKE;
          wake_left <= WAKE_LD;
          waiting   <= 1'b0;
        end else pcnt <= pcnt - 1'b1;
        T_WAKE: if (waiting) begin
          if (eng_done) waiting <= 1'b0;
        end else if (wake_left == '0) begin
          state <= T_IDLE;
          ready <= 1'b1;
        end else begin
          kick      <= 1'b1;
          waiting   <= 1'b1;
          wake_left <= wake_left - 1'b1;
        end
        T_IDLE: if (lapse) begin
          state     <= T_WAKE;
          ready     <= 1'b0;
          wake_left <= WAKE_LD;
          waiting   <= 1'b0;
        end else if (ref_pending) begin
          state   <= T_REF;
          kick    <= 1'b1;
          waiting <= 1'b1;
        end else if (host_req) begin
          state    <= T_HOST;
          host_gnt <= 1'b1;
        end
        T_REF: if (eng_done) begin
          state   <= T_IDLE;
          waiting <= 1'b0;
        end
        T_HOST: if (!host_req) begin
          state    <= T_RECOV;
          host_gnt <= 1'b0;
          pcnt     <= RECOV_LD;
        end
        T_RECOV: if (pcnt == '0) state <= T_IDLE;
                 else pcnt <= pcnt - 1'b1;
        default: state <= T_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
    end else if (state == T_HOST) begin
      dram_ras_n <= host_ras_n;
      dram_cas_n <= host_cas_n;
      dram_we_n  <= host_we_n;
      dram_oe_n  <= host_oe_n;
    end else begin
      dram_ras_n <= eng_ras_n;
      dram_cas_n <= eng_cas_n;
      dram_we_n  <= eng_we_n;
      dram_oe_n  <= 1'b1;
    end
  end

  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == T_PAUSE) |-> (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n));

  // R3
  ready_after_burst_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(state) == T_WAKE));

  // R6
  gnt_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    host_gnt |-> ready);

  // R7
  refresh_before_host_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == T_IDLE) && ref_pending && host_req) |=> !host_gnt);

endmodule

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;

  localparam int CLK_PS    = 20000;
  localparam int PAUSE_CYC = 100;
  localparam int CSR_CYC   = 1;
  localparam int RAS_CYC   = 3;
  localparam int TCP_CYC   = 2;
  localparam int PRE_CYC   = 2;
  localparam int INT_CYC   = 40;
  localparam int INT2K_CYC = 80;
  localparam int WAKE_N    = 8;
  localparam int NVEC      = 5;
  localparam int HOLD  [NVEC] = '{5, 30, 60, 120, 250};
  localparam bit BURST [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0;
  logic h_ras = 1'b1, h_cas = 1'b1, h_we = 1'b1, h_oe = 1'b1;
  logic gnt, rdy, ras, cas, we, oe;
  logic gnt2, rdy2, ras2, cas2, we2, oe2;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .CLK_PERIOD_PS(CLK_PS), .PAUSE_NS(2000), .REFRESH_PERIOD_NS(3276800),
    .ROWS_4K(1'b1), .LAPSE_NS(4000), .TCSR_NS(20), .TRAS_NS(60),
    .TRP_NS(40), .TCP_NS(30), .WAKE_COUNT(WAKE_N)
  ) dut_i (
    .clk(clk), .rst(rst), .host_req(host_req), .host_ras_n(h_ras),
    .host_cas_n(h_cas), .host_we_n(h_we), .host_oe_n(h_oe),
    .host_gnt(gnt), .ready(rdy), .dram_ras_n(ras), .dram_cas_n(cas),
    .dram_we_n(we), .dram_oe_n(oe)
  );

  dram_refresh_seq #(
    .CLK_PERIOD_PS(CLK_PS), .PAUSE_NS(2000), .REFRESH_PERIOD_NS(3276800),
    .ROWS_4K(1'b0), .LAPSE_NS(40000), .TCSR_NS(20), .TRAS_NS(60),
    .TRP_NS(40), .TCP_NS(30), .WAKE_COUNT(WAKE_N)
  ) dut_2k_i (
    .clk(clk), .rst(rst), .host_req(1'b0), .host_ras_n(1'b1),
    .host_cas_n(1'b1), .host_we_n(1'b1), .host_oe_n(1'b1),
    .host_gnt(gnt2), .ready(rdy2), .dram_ras_n(ras2), .dram_cas_n(cas2),
    .dram_we_n(we2), .dram_oe_n(oe2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- strobe monitor (negedge sampling) ----------------
  logic ras_p = 1'b1, cas_p = 1'b1, gnt_p = 1'b0, rdy_p = 1'b0;
  int ras_hi = 0, ras_lo = 0, cas_hi = 0, cas_lo = 0;
  int cyc = 0, last_fall = 0, wake_cnt = 0, bursts = 0, cbr_total = 0;
  bit prev_valid = 1'b0, host_seen = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      ras_p = 1'b1; cas_p = 1'b1; gnt_p = 1'b0; rdy_p = 1'b0;
      ras_hi = 0; ras_lo = 0; cas_hi = 0; cas_lo = 0; wake_cnt = 0;
      prev_valid = 1'b0; host_seen = 1'b0;
    end else begin
      cyc++;
      if (gnt) begin
        host_seen = 1'b1;
        chk(rdy == 1'b1, "R6 grant without ready", int'(rdy), 1);
      end
      if (!gnt_p && ras_p && !ras) begin
        chk(cas == 1'b0 && we == 1'b1, "R4 cas low & we high at ras fall",
            int'({cas, we}), 1);
        chk(cas_lo >= CSR_CYC, "R4 cas setup before ras", cas_lo, CSR_CYC);
        chk(ras_hi >= PRE_CYC, "R8 ras precharge", ras_hi, PRE_CYC);
        cbr_total++;
        if (!rdy) begin
          wake_cnt++;
          prev_valid = 1'b0;
        end else if (host_seen) begin
          prev_valid = 1'b0;
          host_seen = 1'b0;
        end else begin
          if (prev_valid)
            chk(cyc - last_fall == INT_CYC, "R5 refresh interval", cyc - last_fall, INT_CYC);
          prev_valid = 1'b1;
        end
        last_fall = cyc;
      end
      if (!gnt_p && !ras_p && ras)
        chk(ras_lo == RAS_CYC, "R4 ras low width", ras_lo, RAS_CYC);
      if (!gnt_p && cas_p && !cas)
        chk(cas_hi >= TCP_CYC, "R8 cas precharge", cas_hi, TCP_CYC);
      if (!gnt_p && !ras) chk(we == 1'b1, "R4 we high in refresh", int'(we), 1);
      if (!rdy_p && rdy) begin
        chk(wake_cnt == WAKE_N, (bursts == 0) ? "R3 wake burst count" : "R9 repeat burst count",
            wake_cnt, WAKE_N);
        wake_cnt = 0;
        bursts++;
      end
      if (rdy_p && !rdy) wake_cnt = 0;
      ras_hi = ras ? ras_hi + 1 : 0;
      ras_lo = ras ? 0 : ras_lo + 1;
      cas_hi = cas ? cas_hi + 1 : 0;
      cas_lo = cas ? 0 : cas_lo + 1;
      ras_p = ras; cas_p = cas; gnt_p = gnt; rdy_p = rdy;
    end
  end

  // ---------------- host access task ----------------
  task automatic host_access(input int hold);
    bit got = 1'b0;
    @(negedge clk) host_req = 1'b1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (gnt) begin got = 1'b1; break; end
    end
    chk(got, "R6 grant arrives", int'(got), 1);
    h_ras = 1'b0; h_cas = 1'b1; h_we = 1'b1; h_oe = 1'b0;
    @(negedge clk);
    chk({ras, cas, we, oe} == 4'b0110, "R6 pass-through A", int'({ras, cas, we, oe}), 6);
    h_cas = 1'b0; h_we = 1'b0;
    @(negedge clk);
    chk({ras, cas, we, oe} == 4'b0000, "R6 pass-through B", int'({ras, cas, we, oe}), 0);
    repeat (hold - 3) @(negedge clk);
    h_ras = 1'b1; h_cas = 1'b1; h_we = 1'b1; h_oe = 1'b1;
    @(negedge clk) host_req = 1'b0;
    @(negedge clk);
    chk(gnt == 1'b0, "R6 grant falls after req drop", int'(gnt), 0);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int quiet;
    bit seen;
    int c0;
    int t0;
    logic r2p;
    repeat (3) begin
      @(negedge clk);
      chk({ras, cas, we, oe} == 4'b1111 && !rdy && !gnt, "R1 reset state",
          int'({ras, cas, we, oe, rdy, gnt}), 60);
    end
    rst = 1'b0;
    @(negedge clk);
    chk({ras, cas, we, oe} == 4'b1111 && !rdy && !gnt, "R1 state after reset",
        int'({ras, cas, we, oe, rdy, gnt}), 60);
    quiet = 1;
    for (int k = 0; k < 500; k++) begin
      if (!(ras && cas && we && oe)) break;
      if (rdy) chk(1'b0, "R2 ready during pause", 1, 0);
      quiet++;
      @(negedge clk);
    end
    chk(quiet >= PAUSE_CYC && quiet <= PAUSE_CYC + 10, "R2 pause length", quiet, PAUSE_CYC);

    seen = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (rdy) begin seen = 1'b1; break; end
    end
    chk(seen, "R3 ready rises", int'(seen), 1);
    repeat (160) @(negedge clk);

    // vector table: host holds, and whether a repeat burst must follow
    for (int v = 0; v < NVEC; v++) begin
      host_access(HOLD[v]);
      seen = 1'b0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (!rdy) begin seen = 1'b1; break; end
      end
      chk(seen == BURST[v], "R9 ready drop after hold", int'(seen), int'(BURST[v]));
      if (seen) begin
        for (int k = 0; k < 1500; k++) begin
          @(negedge clk);
          if (rdy) break;
        end
        chk(rdy == 1'b1, "R9 ready returns", int'(rdy), 1);
      end
      repeat (130) @(negedge clk);
    end

    // pending refresh beats a new host request
    @(negedge clk) host_req = 1'b1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (gnt) break;
    end
    repeat (60) @(negedge clk);
    host_req = 1'b0;
    @(negedge clk) host_req = 1'b1;
    @(negedge clk);
    c0 = cbr_total;
    seen = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (gnt) begin seen = 1'b1; break; end
    end
    @(negedge clk);
    chk(seen && (cbr_total - c0 == 1), "R7 one deferred refresh before regrant",
        cbr_total - c0, 1);
    host_req = 1'b0;
    repeat (10) @(negedge clk);

    // 2048-row variant interval
    r2p = ras2;
    t0 = -1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (rdy2 && r2p && !ras2) begin
        if (t0 >= 0) begin
          chk(k - t0 == INT2K_CYC, "R5 interval with 2048 rows", k - t0, INT2K_CYC);
          break;
        end
        t0 = k;
      end
      r2p = ras2;
    end
    chk(t0 >= 0, "R5 2048-row refresh seen", t0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule